// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches a stream of CPU bus-cycle descriptors, one per clock, and raises a break flag when a cycle meets a programmed condition. Channel A and channel B work independently. Each channel compares the cycle address with a per-bit mask and checks which bus carried the cycle, whether it was a fetch or a data access, its direction and its operand size. It can also require a matching address-space identifier. Channel B adds a data-value compare with its own per-bit mask, applied only to the byte lanes of the operand size.

Software programs the channels through a simple write-only register port. Each break flag is sticky. It is set in the cycle after a matching valid bus cycle and stays set until software writes 1 to the clear register. The flags feed whatever halts the core, which is outside this block.

Top module: `bkpt_unit`

## Requirements
- R1: After reset both break flags are 0 and both channels are disabled (bus field 00).
- R2: The address compare ignores each bit set to 1 in the channel's address mask. Every other address bit must equal the programmed address.
- R3: Channel B compares data only in the lanes of the operand size (byte bits 7:0, word bits 15:0, longword or size 00 all 32 bits). Within those lanes it ignores each bit set in the data mask.
- R4: Condition bits [1:0] select the bus: 01 I bus, 10 L bus, 11 X/Y bus, which must equal bus_sel_i. The value 00 disables the channel.
- R5: Condition bits [3:2] select the access kind: bit 2 allows an instruction fetch (bus_fetch_i=1) and bit 3 allows a data access.
- R6: Condition bits [5:4] select the direction: bit 4 allows a read (bus_write_i=0) and bit 5 allows a write.
- R7: Condition bits [7:6] give the size: 00 any, 01 byte, 10 word, 11 longword, and a nonzero value must equal bus_size_i. Size is not checked on a fetch.
- R8: Condition bit 8 enables the ASID check. When it is set, bus_asid_i must equal the channel's ASID register. When it is clear, the ASID is ignored.
- R9: A flag is set one cycle after a valid cycle that matches on every field. It holds until a write of 1 to its bit of the clear register (address 10: bit 0 clears A, bit 1 clears B). A match in the same cycle as the clear wins.
- R10: The channels are independent. A cycle that matches only one channel sets only that channel's flag.
- R11: Register map: channel A at 0..3 and channel B at 4..7, in the order address, address mask, condition, ASID. Channel B's data value is at 8 and its data mask at 9. A write takes effect for bus cycles presented from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| bus_valid_i | input | 1 | Bus-cycle descriptor valid |
| bus_sel_i | input | 2 | Bus carrying the cycle (01 I, 10 L, 11 X/Y) |
| bus_fetch_i | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_size_i | input | 2 | Operand size (01 byte, 10 word, 11 longword) |
| bus_addr_i | input | 32 | Cycle address |
| bus_data_i | input | 32 | Cycle data |
| bus_asid_i | input | 8 | Cycle address-space identifier |
| brk_a_o | output | 1 | Sticky break flag, channel A |
| brk_b_o | output | 1 | Sticky break flag, channel B |

## Verification
A corrupted condition, mask or compare register does not change any output until a bus cycle exercises the damaged field. It then shows as a flag that rises, or fails to rise, on the clock after that cycle. A flag register that leaks or loses its state shows as soon as a non-matching cycle or a clear write follows a hit. For that reason every stimulus cycle is followed by a read of both flags one clock later, and the flags are cleared before each new case.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NCH        = 2;
  localparam int COND_W     = 9;
  localparam int REG_STRIDE = 4;
  localparam int OFS_ADDR   = 0;
  localparam int OFS_AMASK  = 1;
  localparam int OFS_COND   = 2;
  localparam int OFS_ASID   = 3;
  localparam int REG_DVAL   = 8;
  localparam int REG_DMASK  = 9;
  localparam int REG_CLR    = 10;

  typedef struct packed {
    logic       asid_en;
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] acc;
    logic [1:0] bus;
  } cond_t;
endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int ASIDW = 8,
  parameter int RAW   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RAW-1:0]   addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [AW-1:0]    ch_addr_o  [NCH],
  output logic [AW-1:0]    ch_amask_o [NCH],
  output cond_t            ch_cond_o  [NCH],
  output logic [ASIDW-1:0] ch_asid_o  [NCH],
  output logic [DW-1:0]    dval_o,
  output logic [DW-1:0]    dmask_o,
  output logic [NCH-1:0]   clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        ch_addr_o[c]  <= '0;
        ch_amask_o[c] <= '0;
        ch_cond_o[c]  <= '0;
        ch_asid_o[c]  <= '0;
      end
      dval_o  <= '0;
      dmask_o <= '0;
    end else if (we_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr_i == RAW'(c*REG_STRIDE + OFS_ADDR))  ch_addr_o[c]  <= wdata_i[AW-1:0];
        if (addr_i == RAW'(c*REG_STRIDE + OFS_AMASK)) ch_amask_o[c] <= wdata_i[AW-1:0];
        if (addr_i == RAW'(c*REG_STRIDE + OFS_COND))  ch_cond_o[c]  <= cond_t'(wdata_i[COND_W-1:0]);
        if (addr_i == RAW'(c*REG_STRIDE + OFS_ASID))  ch_asid_o[c]  <= wdata_i[ASIDW-1:0];
      end
      if (addr_i == RAW'(REG_DVAL))  dval_o  <= wdata_i;
      if (addr_i == RAW'(REG_DMASK)) dmask_o <= wdata_i;
    end
  end

  assign clr_o = {NCH{we_i && (addr_i == RAW'(REG_CLR))}} & wdata_i[NCH-1:0];
endmodule

// File: rtl/bkpt_chan.sv
module bkpt_chan
  import bkpt_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ASIDW    = 8,
  parameter bit HAS_DATA = 1'b0
) (
  input  cond_t            cond_i,
  input  logic [AW-1:0]    cmp_addr_i,
  input  logic [AW-1:0]    amask_i,
  input  logic [ASIDW-1:0] cmp_asid_i,
  input  logic [DW-1:0]    dval_i,
  input  logic [DW-1:0]    dmask_i,
  input  logic             valid_i,
  input  logic [1:0]       sel_i,
  input  logic             fetch_i,
  input  logic             write_i,
  input  logic [1:0]       size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [ASIDW-1:0] asid_i,
  output logic             hit_o
);
  localparam logic [DW-1:0] LANE_B = {{(DW-8){1'b0}}, 8'hFF};
  localparam logic [DW-1:0] LANE_H = {{(DW-16){1'b0}}, 16'hFFFF};

  logic [DW-1:0] lane;
  logic bus_ok, acc_ok, dir_ok, size_ok, asid_ok, addr_ok, data_ok;

  always_comb begin
    unique case (size_i)
      2'b01:   lane = LANE_B;
      2'b10:   lane = LANE_H;
      default: lane = '1;
    endcase
    bus_ok  = (cond_i.bus != 2'b00) && (cond_i.bus == sel_i);
    acc_ok  = fetch_i ? cond_i.acc[0] : cond_i.acc[1];
    dir_ok  = write_i ? cond_i.dir[1] : cond_i.dir[0];
    size_ok = fetch_i || (cond_i.size == 2'b00) || (cond_i.size == size_i);
    asid_ok = !cond_i.asid_en || (asid_i == cmp_asid_i);
    addr_ok = ((addr_i ^ cmp_addr_i) & ~amask_i) == '0;
    data_ok = !HAS_DATA || (((data_i ^ dval_i) & ~dmask_i & lane) == '0);
    hit_o   = valid_i && bus_ok && acc_ok && dir_ok && size_ok
              && asid_ok && addr_ok && data_ok;
  end
endmodule

// File: rtl/bkpt_flag.sv
module bkpt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int ASIDW = 8,
  parameter int RAW   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [RAW-1:0]   cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  input  logic             bus_valid_i,
  input  logic [1:0]       bus_sel_i,
  input  logic             bus_fetch_i,
  input  logic             bus_write_i,
  input  logic [1:0]       bus_size_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_data_i,
  input  logic [ASIDW-1:0] bus_asid_i,
  output logic             brk_a_o,
  output logic             brk_b_o
);
  logic [AW-1:0]    ch_addr  [NCH];
  logic [AW-1:0]    ch_amask [NCH];
  cond_t            ch_cond  [NCH];
  logic [ASIDW-1:0] ch_asid  [NCH];
  logic [DW-1:0]    dval, dmask;
  logic [NCH-1:0]   clr_w, hit_w, flag_w;

  bkpt_cfg_regs #(.AW(AW), .DW(DW), .ASIDW(ASIDW), .RAW(RAW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ch_addr_o(ch_addr), .ch_amask_o(ch_amask), .ch_cond_o(ch_cond),
    .ch_asid_o(ch_asid), .dval_o(dval), .dmask_o(dmask), .clr_o(clr_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    bkpt_chan #(.AW(AW), .DW(DW), .ASIDW(ASIDW), .HAS_DATA(g == 1)) u_chan (
      .cond_i(ch_cond[g]), .cmp_addr_i(ch_addr[g]), .amask_i(ch_amask[g]),
      .cmp_asid_i(ch_asid[g]), .dval_i(dval), .dmask_i(dmask),
      .valid_i(bus_valid_i), .sel_i(bus_sel_i), .fetch_i(bus_fetch_i),
      .write_i(bus_write_i), .size_i(bus_size_i), .addr_i(bus_addr_i),
      .data_i(bus_data_i), .asid_i(bus_asid_i), .hit_o(hit_w[g])
    );
    bkpt_flag u_flag (
      .clk_i, .rst_ni, .set_i(hit_w[g]), .clr_i(clr_w[g]), .flag_o(flag_w[g])
    );
  end

  assign brk_a_o = flag_w[0];
  assign brk_b_o = flag_w[1];
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int RAW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_we_i,
  input logic [RAW-1:0] cfg_addr_i,
  input logic [1:0]     clr_bits_i,
  input logic           bus_valid_i,
  input logic [1:0]     hit_i,
  input logic           brk_a_o,
  input logic           brk_b_o
);
  localparam logic [RAW-1:0] CLR_ADDR = RAW'(bkpt_pkg::REG_CLR);
  logic clr_a, clr_b;
  assign clr_a = cfg_we_i && (cfg_addr_i == CLR_ADDR) && clr_bits_i[0];
  assign clr_b = cfg_we_i && (cfg_addr_i == CLR_ADDR) && clr_bits_i[1];

  assert_rise_after_valid_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_a_o) |-> $past(bus_valid_i));
  assert_rise_after_valid_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_b_o) |-> $past(bus_valid_i));
  assert_sticky_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_a_o && !clr_a |=> brk_a_o);
  assert_sticky_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_b_o && !clr_b |=> brk_b_o);
  assert_clear_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_a && !hit_i[0] |=> !brk_a_o);
  assert_clear_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_b && !hit_i[1] |=> !brk_b_o);
  assert_hit_sets_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[0] |=> brk_a_o);
  assert_hit_sets_b_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[1] |=> brk_b_o);
endmodule

bind bkpt_unit bkpt_unit_chk #(.RAW(RAW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .clr_bits_i(cfg_wdata_i[1:0]), .bus_valid_i(bus_valid_i), .hit_i(hit_w),
  .brk_a_o(brk_a_o), .brk_b_o(brk_b_o)
);

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        b_valid = 1'b0, b_fetch = 1'b0, b_write = 1'b0;
  logic [1:0]  b_sel = '0, b_size = '0;
  logic [31:0] b_addr = '0, b_data = '0;
  logic [7:0]  b_asid = '0;
  logic        brk_a, brk_b;

  int total = 0, bad = 0;

  logic [31:0] m_addr [2];
  logic [31:0] m_amask[2];
  logic [8:0]  m_cond [2];
  logic [7:0]  m_asid [2];
  logic [31:0] m_dval, m_dmask;

  always #10ns clk = ~clk;  // 50 MHz

  bkpt_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .bus_valid_i(b_valid), .bus_sel_i(b_sel),
    .bus_fetch_i(b_fetch), .bus_write_i(b_write), .bus_size_i(b_size),
    .bus_addr_i(b_addr), .bus_data_i(b_data), .bus_asid_i(b_asid),
    .brk_a_o(brk_a), .brk_b_o(brk_b)
  );

  function automatic logic [8:0] mk_cond(bit en, logic [1:0] sz, logic [1:0] dir,
                                         logic [1:0] acc, logic [1:0] bus);
    return {en, sz, dir, acc, bus};
  endfunction

  function automatic bit ref_hit(int ch, logic [1:0] sel, bit fetch, bit wr,
                                 logic [1:0] sz, logic [31:0] a, logic [31:0] d,
                                 logic [7:0] asid);
    logic [8:0]  c = m_cond[ch];
    logic [31:0] lane = (sz == 2'b01) ? 32'hFF : (sz == 2'b10) ? 32'hFFFF : 32'hFFFF_FFFF;
    bit ok = (c[1:0] != 2'b00) && (c[1:0] == sel);
    ok &= fetch ? c[2] : c[3];
    ok &= wr ? c[5] : c[4];
    ok &= fetch || (c[7:6] == 2'b00) || (c[7:6] == sz);
    ok &= !c[8] || (asid == m_asid[ch]);
    ok &= ((a ^ m_addr[ch]) & ~m_amask[ch]) == 32'h0;
    if (ch == 1) ok &= ((d ^ m_dval) & ~m_dmask & lane) == 32'h0;
    return ok;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog_ch(int ch, logic [31:0] a, logic [31:0] am, logic [8:0] c, logic [7:0] asid);
    cfg_wr(4'(ch*4 + 0), a);
    cfg_wr(4'(ch*4 + 1), am);
    cfg_wr(4'(ch*4 + 2), {23'h0, c});
    cfg_wr(4'(ch*4 + 3), {24'h0, asid});
    m_addr[ch] = a; m_amask[ch] = am; m_cond[ch] = c; m_asid[ch] = asid;
  endtask

  task automatic prog_data(logic [31:0] v, logic [31:0] m);
    cfg_wr(4'd8, v); cfg_wr(4'd9, m);
    m_dval = v; m_dmask = m;
  endtask

  task automatic clear_flags();
    cfg_wr(4'd10, 32'h3);
  endtask

  task automatic run_cyc(logic [1:0] sel, bit fetch, bit wr, logic [1:0] sz,
                         logic [31:0] a, logic [31:0] d, logic [7:0] asid);
    @(negedge clk);
    b_valid = 1'b1; b_sel = sel; b_fetch = fetch; b_write = wr;
    b_size = sz; b_addr = a; b_data = d; b_asid = asid;
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic hit_test(string tag, bit ea, bit eb, logic [1:0] sel, bit fetch, bit wr,
                          logic [1:0] sz, logic [31:0] a, logic [31:0] d, logic [7:0] asid);
    clear_flags();
    run_cyc(sel, fetch, wr, sz, a, d, asid);
    chk({tag, " A"}, brk_a, ea);
    chk({tag, " B"}, brk_b, eb);
  endtask

  initial begin
    #(20ns * 150000);
    bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset A", brk_a, 1'b0);
    chk("R1 reset B", brk_b, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < 2; c++) begin
      m_addr[c] = '0; m_amask[c] = '0; m_cond[c] = '0; m_asid[c] = '0;
    end
    m_dval = '0; m_dmask = '0;
    // R1: disabled channels ignore an all-zero cycle
    hit_test("R1 disabled after reset", 0, 0, 2'b01, 1'b0, 1'b0, 2'b11, 32'h0, 32'h0, 8'h0);

    // R11 map: A = L bus data read word; B = X/Y data write word, masked address
    prog_ch(0, 32'h0100_0000, 32'h0, mk_cond(0, 2'b10, 2'b01, 2'b10, 2'b10), 8'h0);
    prog_ch(1, 32'h0000_F000, 32'hFFFF_0000, mk_cond(0, 2'b10, 2'b10, 2'b10, 2'b11), 8'h0);
    prog_data(32'h0000_4567, 32'h0);
    hit_test("R2 R10 masked hit B only", 0, 1, 2'b11, 0, 1, 2'b10, 32'h1234_F000, 32'hAAAA_4567, 8'h5);
    hit_test("R2 unmasked bit miss", 0, 0, 2'b11, 0, 1, 2'b10, 32'h1234_F001, 32'h4567, 8'h0);
    hit_test("R3 data miss", 0, 0, 2'b11, 0, 1, 2'b10, 32'h0000_F000, 32'h4568, 8'h0);
    hit_test("R10 A only", 1, 0, 2'b10, 0, 0, 2'b10, 32'h0100_0000, 32'h0, 8'h0);
    hit_test("R6 wrong direction", 0, 0, 2'b10, 0, 1, 2'b10, 32'h0100_0000, 32'h0, 8'h0);
    hit_test("R4 wrong bus", 0, 0, 2'b01, 0, 0, 2'b10, 32'h0100_0000, 32'h0, 8'h0);
    hit_test("R7 wrong size", 0, 0, 2'b10, 0, 0, 2'b01, 32'h0100_0000, 32'h0, 8'h0);

    // A = I bus fetch with ASID 80; B = I bus byte write ASID 70 data 7x
    prog_ch(0, 32'h0031_4156, 32'h0, mk_cond(1, 2'b10, 2'b01, 2'b01, 2'b01), 8'h80);
    prog_ch(1, 32'h0005_5555, 32'h0, mk_cond(1, 2'b01, 2'b10, 2'b10, 2'b01), 8'h70);
    prog_data(32'h0000_0078, 32'h0000_000F);
    hit_test("R7 fetch ignores size", 1, 0, 2'b01, 1, 0, 2'b01, 32'h0031_4156, 32'h0, 8'h80);
    hit_test("R8 asid mismatch A", 0, 0, 2'b01, 1, 0, 2'b10, 32'h0031_4156, 32'h0, 8'h81);
    hit_test("R5 data access vs fetch cond", 0, 0, 2'b01, 0, 0, 2'b10, 32'h0031_4156, 32'h0, 8'h80);
    hit_test("R3 nibble dont-care byte lane", 0, 1, 2'b01, 0, 1, 2'b01, 32'h0005_5555, 32'hABCD_EF7C, 8'h70);
    hit_test("R3 high nibble miss", 0, 0, 2'b01, 0, 1, 2'b01, 32'h0005_5555, 32'h0000_0068, 8'h70);
    hit_test("R8 asid mismatch B", 0, 0, 2'b01, 0, 1, 2'b01, 32'h0005_5555, 32'h78, 8'h71);
    hit_test("R5 fetch vs data cond B", 0, 0, 2'b01, 1, 1, 2'b01, 32'h0005_5555, 32'h78, 8'h70);

    // R9 sticky, clear, set-wins
    hit_test("R9 set", 0, 1, 2'b01, 0, 1, 2'b01, 32'h0005_5555, 32'h71, 8'h70);
    run_cyc(2'b01, 0, 1, 2'b01, 32'h0005_5555, 32'h71, 8'h71);
    chk("R9 sticky after miss B", brk_b, 1'b1);
    clear_flags();
    chk("R9 cleared B", brk_b, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd10; cfg_wdata = 32'h3;
    b_valid = 1'b1; b_sel = 2'b01; b_fetch = 1'b0; b_write = 1'b1; b_size = 2'b01;
    b_addr = 32'h0005_5555; b_data = 32'h7F; b_asid = 8'h70;
    @(negedge clk);
    cfg_we = 1'b0; b_valid = 1'b0;
    chk("R9 set wins over clear B", brk_b, 1'b1);
    chk("R9 clear without hit A", brk_a, 1'b0);

    // R4 disable via bus field 00
    prog_ch(0, 32'h0031_4156, 32'h0, mk_cond(1, 2'b10, 2'b01, 2'b01, 2'b00), 8'h80);
    hit_test("R4 bus 00 disables", 0, 0, 2'b01, 1, 0, 2'b01, 32'h0031_4156, 32'h0, 8'h80);

    // Random: all fields, checked against the bench model
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) begin
        for (int c = 0; c < 2; c++)
          prog_ch(c, $urandom, $urandom & $urandom,
                  mk_cond(1'($urandom), 2'($urandom), 2'($urandom_range(1, 3)),
                          2'($urandom_range(1, 3)), 2'($urandom_range(0, 3))),
                  8'($urandom_range(0, 3)));
        prog_data($urandom, $urandom & $urandom & 32'hFFFF_FF0F);
      end
      begin
        int ch = $urandom_range(0, 1);
        logic [1:0]  sel = 2'($urandom_range(1, 3));
        bit          f = 1'($urandom);
        bit          w = 1'($urandom);
        logic [1:0]  sz = 2'($urandom_range(1, 3));
        logic [31:0] a = ($urandom_range(0, 3) != 0) ? (m_addr[ch] ^ ($urandom & m_amask[ch])) : $urandom;
        logic [31:0] d = ($urandom_range(0, 3) != 0) ? (m_dval ^ ($urandom & m_dmask) ^ ($urandom & 32'hFFFF_0000)) : $urandom;
        logic [7:0]  as = 8'($urandom_range(0, 3));
        bit ea = ref_hit(0, sel, f, w, sz, a, d, as);
        bit eb = ref_hit(1, sel, f, w, sz, a, d, as);
        hit_test("R2 R3 R4 R5 R6 R7 R8 random", ea, eb, sel, f, w, sz, a, d, as);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule